// File: doc/BRIEF.md
# Vector Multiply-Accumulate Engine

This block multiplies two 128-bit vector operands element by element with signed two's complement arithmetic and folds the products into accumulators. It has two accumulation targets. The first is a wide per-lane accumulator of 512 bits, split into a high half and a low half of 256 bits each. It holds sixteen 32-bit slices when the operands are taken as 8-bit elements, or eight 64-bit slices when they are taken as 16-bit elements. The second is a single 40-bit scalar accumulator. In dot-product mode it takes the sum of every lane product.

Software-visible storage and memory traffic live outside the block. Operands, preload values and control strobes arrive on ports. The accumulators can be cleared or preloaded. A combinational read-out path picks one lane slice or the scalar, shifts it right arithmetically, and saturates it to a signed 8-bit or 16-bit result.

Top module: `vmac_unit`

## Requirements
- R1: With `wide_i`=0 and `op_i`=0, a strobe on `valid_i` adds the signed product of `a_i[8i+7:8i]` and `b_i[8i+7:8i]`, sign-extended to 32 bits, into slice i (bits 32i+31..32i of {`acc_hi_o`,`acc_lo_o`}) for i = 0..15. Each slice wraps modulo 2^32 with no carry into its neighbour.
- R2: With `wide_i`=1 and `op_i`=0, a strobe adds the signed product of `a_i[16j+15:16j]` and `b_i[16j+15:16j]`, sign-extended to 64 bits, into slice j (bits 64j+63..64j) for j = 0..7. Each slice wraps modulo 2^64.
- R3: With `op_i`=1, a strobe adds the sum of all lane products for the selected element width into `acc_scal_o`, modulo 2^40. The lane accumulators are left unchanged. A lane-mode strobe leaves `acc_scal_o` unchanged.
- R4: `clr_i` zeroes both accumulators at the next clock edge. It takes priority over `load_i` and `valid_i`.
- R5: `load_i` with `clr_i` low writes {`ld_hi_i`,`ld_lo_i`} into the lane accumulator and `ld_scal_i` into the scalar at the next edge. It overrides any MAC strobe in the same cycle.
- R6: `rd_o` is combinational. The source is the scalar when `rd_src_i`=1. Otherwise it is lane `rd_lane_i`, taken as a 32-bit slice when `wide_i`=0 or a 64-bit slice when `wide_i`=1, in both cases sign-extended. The source is shifted right arithmetically by `rd_shift_i`. The result then saturates to signed 16 bits when `rd_n16_i`=1, or to signed 8 bits sign-extended to 16 when `rd_n16_i`=0.
- R7: With `valid_i`, `clr_i` and `load_i` all low, both accumulators hold their values.
- R8: While `rst_ni` is low, both accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | MAC strobe |
| op_i | input | 1 | 0 lane accumulate, 1 dot product into scalar |
| wide_i | input | 1 | 0 for 8-bit elements, 1 for 16-bit elements |
| clr_i | input | 1 | Clear both accumulators |
| load_i | input | 1 | Preload both accumulators |
| a_i | input | 128 | Vector operand A |
| b_i | input | 128 | Vector operand B |
| ld_hi_i | input | 256 | Preload value, high half |
| ld_lo_i | input | 256 | Preload value, low half |
| ld_scal_i | input | 40 | Preload value, scalar |
| rd_src_i | input | 1 | Read-out source: 0 lane, 1 scalar |
| rd_lane_i | input | 4 | Read-out lane index |
| rd_shift_i | input | 6 | Read-out right shift |
| rd_n16_i | input | 1 | Read-out width: 1 for 16-bit, 0 for 8-bit |
| acc_hi_o | output | 256 | Lane accumulator, high half |
| acc_lo_o | output | 256 | Lane accumulator, low half |
| acc_scal_o | output | 40 | Scalar accumulator |
| rd_o | output | 16 | Shifted, saturated read-out |

## Verification
Accumulator effects of a strobe, a clear or a load appear on the outputs one clock edge later. The read-out path has no register, so `rd_o` follows its inputs within the same cycle. The driver applies each request just after a falling edge and queues the accumulator state it expects after the next rising edge. The monitor compares that state 1 ns after that rising edge. Read-out selections are applied at a falling edge and compared once they settle, against the state the bench model already holds for that cycle.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  localparam int unsigned SLICE8_W  = 32;
  localparam int unsigned SLICE16_W = 64;
  localparam int unsigned RD_W      = 16;

  typedef enum logic {
    OP_LANE = 1'b0,
    OP_DOT  = 1'b1
  } op_e;
endpackage

// File: rtl/vmac_mul.sv
module vmac_mul
  import vmac_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned SCAL_W = 40,
  localparam int unsigned N8    = VEC_W / 8,
  localparam int unsigned N16   = VEC_W / 16,
  localparam int unsigned ACC_W = N8 * SLICE8_W
) (
  input  logic [VEC_W-1:0]  a_i,
  input  logic [VEC_W-1:0]  b_i,
  input  logic              wide_i,
  output logic [ACC_W-1:0]  inc_o,
  output logic [SCAL_W-1:0] sum_o
);
  logic signed [15:0] p8  [N8];
  logic signed [31:0] p16 [N16];

  for (genvar i = 0; i < N8; i++) begin : g_m8
    assign p8[i] = $signed(a_i[8*i +: 8]) * $signed(b_i[8*i +: 8]);
  end
  for (genvar j = 0; j < N16; j++) begin : g_m16
    assign p16[j] = $signed(a_i[16*j +: 16]) * $signed(b_i[16*j +: 16]);
  end

  always_comb begin
    inc_o = '0;
    sum_o = '0;
    if (wide_i) begin
      for (int j = 0; j < N16; j++) begin
        inc_o[SLICE16_W*j +: SLICE16_W] = SLICE16_W'(p16[j]);
        sum_o = sum_o + SCAL_W'(p16[j]);
      end
    end else begin
      for (int i = 0; i < N8; i++) begin
        inc_o[SLICE8_W*i +: SLICE8_W] = SLICE8_W'(p8[i]);
        sum_o = sum_o + SCAL_W'(p8[i]);
      end
    end
  end
endmodule

// File: rtl/vmac_lane_acc.sv
module vmac_lane_acc
  import vmac_pkg::*;
#(
  parameter int unsigned N8     = 16,
  localparam int unsigned ACC_W = N8 * SLICE8_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             en_i,
  input  logic             wide_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] ld_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] sum_w;

  // 32-bit slices; carry chains pairwise in 16-bit mode to form 64-bit slices
  always_comb begin
    logic            cy;
    logic [SLICE8_W:0] t;
    cy    = 1'b0;
    sum_w = '0;
    for (int i = 0; i < N8; i++) begin
      t = {1'b0, acc_o[SLICE8_W*i +: SLICE8_W]} + {1'b0, inc_i[SLICE8_W*i +: SLICE8_W]}
          + (SLICE8_W+1)'((wide_i && (i % 2 == 1)) ? cy : 1'b0);
      sum_w[SLICE8_W*i +: SLICE8_W] = t[SLICE8_W-1:0];
      cy = t[SLICE8_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (clr_i)  acc_o <= '0;
    else if (load_i) acc_o <= ld_i;
    else if (en_i)   acc_o <= sum_w;
  end

  AST_LANE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0); // R4
  AST_LANE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> acc_o == $past(ld_i)); // R5
  AST_LANE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i && !load_i) |=> $stable(acc_o)); // R7
endmodule

// File: rtl/vmac_dot_acc.sv
module vmac_dot_acc #(
  parameter int unsigned SCAL_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              en_i,
  input  logic [SCAL_W-1:0] sum_i,
  input  logic [SCAL_W-1:0] ld_i,
  output logic [SCAL_W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (clr_i)  acc_o <= '0;
    else if (load_i) acc_o <= ld_i;
    else if (en_i)   acc_o <= acc_o + sum_i;
  end

  AST_SCAL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0); // R4
  AST_SCAL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> acc_o == $past(ld_i)); // R5
  AST_SCAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i && !load_i) |=> $stable(acc_o)); // R3
endmodule

// File: rtl/vmac_narrow.sv
module vmac_narrow
  import vmac_pkg::*;
#(
  parameter int unsigned N8     = 16,
  parameter int unsigned SCAL_W = 40,
  localparam int unsigned ACC_W = N8 * SLICE8_W,
  localparam int unsigned LN_W  = $clog2(N8),
  localparam int unsigned SH_W  = $clog2(SLICE16_W)
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [SCAL_W-1:0] scal_i,
  input  logic              src_i,
  input  logic [LN_W-1:0]   lane_i,
  input  logic              wide_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic              n16_i,
  output logic [RD_W-1:0]   rd_o
);
  logic signed [SLICE16_W-1:0] v, sh;

  always_comb begin
    if (src_i)
      v = SLICE16_W'($signed(scal_i));
    else if (wide_i)
      v = acc_i[SLICE16_W*lane_i[LN_W-2:0] +: SLICE16_W];
    else
      v = SLICE16_W'($signed(acc_i[SLICE8_W*lane_i +: SLICE8_W]));
    sh = v >>> shift_i;
    if (n16_i) begin
      if (sh > 64'sd32767)       rd_o = 16'h7fff;
      else if (sh < -64'sd32768) rd_o = 16'h8000;
      else                       rd_o = sh[15:0];
    end else begin
      if (sh > 64'sd127)         rd_o = 16'h007f;
      else if (sh < -64'sd128)   rd_o = 16'hff80;
      else                       rd_o = {{8{sh[7]}}, sh[7:0]};
    end
  end
endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
  import vmac_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned SCAL_W = 40,
  localparam int unsigned N8     = VEC_W / 8,
  localparam int unsigned ACC_W  = N8 * SLICE8_W,
  localparam int unsigned HALF_W = ACC_W / 2,
  localparam int unsigned LN_W   = $clog2(N8),
  localparam int unsigned SH_W   = $clog2(SLICE16_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic              wide_i,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [VEC_W-1:0]  a_i,
  input  logic [VEC_W-1:0]  b_i,
  input  logic [HALF_W-1:0] ld_hi_i,
  input  logic [HALF_W-1:0] ld_lo_i,
  input  logic [SCAL_W-1:0] ld_scal_i,
  input  logic              rd_src_i,
  input  logic [LN_W-1:0]   rd_lane_i,
  input  logic [SH_W-1:0]   rd_shift_i,
  input  logic              rd_n16_i,
  output logic [HALF_W-1:0] acc_hi_o,
  output logic [HALF_W-1:0] acc_lo_o,
  output logic [SCAL_W-1:0] acc_scal_o,
  output logic [RD_W-1:0]   rd_o
);
  logic [ACC_W-1:0]  inc_w, acc_w;
  logic [SCAL_W-1:0] sum_w;
  logic              lane_en, dot_en;

  assign lane_en = valid_i && (op_e'(op_i) == OP_LANE);
  assign dot_en  = valid_i && (op_e'(op_i) == OP_DOT);

  vmac_mul #(.VEC_W(VEC_W), .SCAL_W(SCAL_W)) u_mul (
    .a_i(a_i), .b_i(b_i), .wide_i(wide_i), .inc_o(inc_w), .sum_o(sum_w)
  );

  vmac_lane_acc #(.N8(N8)) u_lane (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .load_i(load_i),
    .en_i(lane_en), .wide_i(wide_i), .inc_i(inc_w),
    .ld_i({ld_hi_i, ld_lo_i}), .acc_o(acc_w)
  );

  vmac_dot_acc #(.SCAL_W(SCAL_W)) u_dot (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .load_i(load_i),
    .en_i(dot_en), .sum_i(sum_w), .ld_i(ld_scal_i), .acc_o(acc_scal_o)
  );

  vmac_narrow #(.N8(N8), .SCAL_W(SCAL_W)) u_narrow (
    .acc_i(acc_w), .scal_i(acc_scal_o), .src_i(rd_src_i), .lane_i(rd_lane_i),
    .wide_i(wide_i), .shift_i(rd_shift_i), .n16_i(rd_n16_i), .rd_o(rd_o)
  );

  assign acc_hi_o = acc_w[ACC_W-1:HALF_W];
  assign acc_lo_o = acc_w[HALF_W-1:0];

  AST_DOT_KEEPS_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en && !clr_i && !load_i) |=> $stable(acc_w)); // R3
  AST_LANE_KEEPS_SCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_en && !clr_i && !load_i) |=> $stable(acc_scal_o)); // R3
  AST_RD8_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n16_i |-> (rd_o[15:7] == 9'h000 || rd_o[15:7] == 9'h1ff)); // R6
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (acc_w == '0 && acc_scal_o == '0)); // R8
endmodule

// File: tb/vmac_unit_test.sv
`timescale 1ns/1ps
module vmac_unit_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 0, op_i = 0, wide_i = 0, clr_i = 0, load_i = 0;
  logic [127:0] a_i = '0, b_i = '0;
  logic [255:0] ld_hi_i = '0, ld_lo_i = '0;
  logic [39:0]  ld_scal_i = '0;
  logic rd_src_i = 0, rd_n16_i = 0;
  logic [3:0] rd_lane_i = '0;
  logic [5:0] rd_shift_i = '0;
  logic [255:0] acc_hi_o, acc_lo_o;
  logic [39:0]  acc_scal_o;
  logic [15:0]  rd_o;

  always #2.5 clk = ~clk;

  vmac_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .wide_i(wide_i),
    .clr_i(clr_i), .load_i(load_i), .a_i(a_i), .b_i(b_i), .ld_hi_i(ld_hi_i),
    .ld_lo_i(ld_lo_i), .ld_scal_i(ld_scal_i), .rd_src_i(rd_src_i),
    .rd_lane_i(rd_lane_i), .rd_shift_i(rd_shift_i), .rd_n16_i(rd_n16_i),
    .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .acc_scal_o(acc_scal_o), .rd_o(rd_o)
  );

  typedef struct {
    logic [511:0] acc;
    logic [39:0]  scal;
    string        req;
  } exp_t;

  exp_t         sb_q[$];
  logic [511:0] m_acc = '0;
  logic [39:0]  m_scal = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // monitor: compare one queued item 1 ns after each rising edge
  initial forever begin
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if ({acc_hi_o, acc_lo_o} !== e.acc || acc_scal_o !== e.scal) begin
        n_fail++;
        $display("FAIL %s: acc=%h scal=%h expected acc=%h scal=%h",
                 e.req, {acc_hi_o, acc_lo_o}, acc_scal_o, e.acc, e.scal);
      end
    end
  end

  task automatic drive(input bit v, input bit dot, input bit wd, input bit clr,
                       input bit ld, input logic [127:0] a, input logic [127:0] b,
                       input logic [511:0] ldv, input logic [39:0] lds, input string req);
    @(negedge clk);
    valid_i = v; op_i = dot; wide_i = wd; clr_i = clr; load_i = ld;
    a_i = a; b_i = b; {ld_hi_i, ld_lo_i} = ldv; ld_scal_i = lds;
    if (clr) begin
      m_acc = '0; m_scal = '0;
    end else if (ld) begin
      m_acc = ldv; m_scal = lds;
    end else if (v) begin
      longint s;
      s = 0;
      if (wd) begin
        for (int j = 0; j < 8; j++) begin
          logic signed [15:0] x, y;
          longint p;
          x = a[16*j +: 16]; y = b[16*j +: 16];
          p = longint'(x) * longint'(y);
          s += p;
          if (!dot) m_acc[64*j +: 64] = m_acc[64*j +: 64] + 64'(p);
        end
      end else begin
        for (int i = 0; i < 16; i++) begin
          logic signed [7:0] x, y;
          longint p;
          x = a[8*i +: 8]; y = b[8*i +: 8];
          p = longint'(x) * longint'(y);
          s += p;
          if (!dot) m_acc[32*i +: 32] = m_acc[32*i +: 32] + 32'(p);
        end
      end
      if (dot) m_scal = m_scal + 40'(s);
    end
    sb_q.push_back('{m_acc, m_scal, req});
    @(posedge clk);
  endtask

  task automatic mac(input bit dot, input bit wd, input logic [127:0] a,
                     input logic [127:0] b, input string req);
    drive(1, dot, wd, 0, 0, a, b, '0, '0, req);
  endtask

  function automatic logic [15:0] ref_rd(bit src, int lane, bit wd, int sh, bit n16);
    longint v;
    if (src)     v = longint'($signed(m_scal));
    else if (wd) v = longint'(m_acc[64*(lane%8) +: 64]);
    else         v = longint'($signed(m_acc[32*lane +: 32]));
    v = v >>> sh;
    if (n16) begin
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
    end else begin
      if (v > 127) v = 127;
      if (v < -128) v = -128;
    end
    return 16'(v);
  endfunction

  task automatic readout(input bit src, input int lane, input bit wd, input int sh,
                         input bit n16);
    logic [15:0] e;
    @(negedge clk);
    valid_i = 0; clr_i = 0; load_i = 0;
    rd_src_i = src; rd_lane_i = 4'(lane); wide_i = wd; rd_shift_i = 6'(sh); rd_n16_i = n16;
    #1;
    e = ref_rd(src, lane, wd, sh, n16);
    n_chk++;
    if (rd_o !== e) begin
      n_fail++;
      $display("FAIL R6: src=%0d lane=%0d wide=%0d sh=%0d n16=%0d rd=%h expected %h",
               src, lane, wd, sh, n16, rd_o, e);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [511:0] lv;
    repeat (3) @(posedge clk);
    // R8: zero while in reset
    @(negedge clk);
    n_chk++;
    if ({acc_hi_o, acc_lo_o} !== '0 || acc_scal_o !== '0) begin
      n_fail++;
      $display("FAIL R8: acc=%h scal=%h expected 0", {acc_hi_o, acc_lo_o}, acc_scal_o);
    end
    rst_ni = 1'b1;

    // R1: 8-bit lanes, several patterns
    mac(0, 0, {16{8'h03}}, {16{8'hfe}}, "R1 small");
    mac(0, 0, {16{8'h80}}, {16{8'h80}}, "R1 extreme");
    for (int k = 0; k < 6; k++) mac(0, 0, rnd128(), rnd128(), "R1 random");
    // R7: idle holds
    drive(0, 0, 0, 0, 0, rnd128(), rnd128(), '1, '1, "R7 idle");
    drive(0, 1, 1, 0, 0, rnd128(), rnd128(), '0, '0, "R7 idle");
    // R1 wrap without carry into neighbour slice
    lv = '0; lv[31:0] = 32'h7fff_ffff; lv[63:32] = 32'h0000_0005;
    drive(0, 0, 0, 0, 1, '0, '0, lv, 40'h0, "R5 preload");
    mac(0, 0, 128'h0001, 128'h0001, "R1 wrap");
    lv = '0; lv[31:0] = 32'hffff_ffff;
    drive(0, 0, 0, 0, 1, '0, '0, lv, 40'h0, "R5 preload");
    mac(0, 0, 128'h0001, 128'h0001, "R1 no carry");
    // R2: 16-bit lanes, carry crosses into upper word
    drive(0, 0, 0, 0, 1, '0, '0, lv, 40'h0, "R5 preload");
    mac(0, 1, 128'h0001, 128'h0001, "R2 carry");
    mac(0, 1, {8{16'h8000}}, {8{16'h8000}}, "R2 extreme");
    for (int k = 0; k < 6; k++) mac(0, 1, rnd128(), rnd128(), "R2 random");
    // R3: dot product, both widths, scalar wrap
    for (int k = 0; k < 4; k++) mac(1, 0, rnd128(), rnd128(), "R3 dot8");
    for (int k = 0; k < 4; k++) mac(1, 1, rnd128(), rnd128(), "R3 dot16");
    drive(0, 0, 0, 0, 1, '0, '0, {16{32'h1234_5678}}, 40'h7f_ffff_fff0, "R5 preload");
    mac(1, 1, {8{16'h0010}}, {8{16'h0010}}, "R3 wrap");
    mac(1, 0, {16{8'h7f}}, {16{8'h81}}, "R3 negative");
    // R4: clear wins over load and valid
    drive(1, 0, 0, 1, 1, rnd128(), rnd128(), '1, '1, "R4 clear priority");
    // R5: load wins over valid
    drive(1, 1, 0, 0, 1, rnd128(), rnd128(), {rnd128(), rnd128(), rnd128(), rnd128()},
          40'h12_3456_789a, "R5 load over mac");
    // R6: read-out
    for (int l = 0; l < 16; l++) readout(0, l, 0, l, l % 2);
    for (int l = 0; l < 8; l++) readout(0, l, 1, 4 * l, l % 2);
    readout(1, 0, 0, 0, 1);
    readout(1, 0, 0, 20, 0);
    drive(0, 0, 0, 0, 1, '0, '0, {{15{32'h0}}, 32'h8000_0000}, 40'h80_0000_0000, "R5 preload");
    readout(1, 0, 0, 0, 1);
    readout(1, 0, 0, 0, 0);
    readout(0, 0, 0, 0, 1);
    readout(0, 0, 0, 24, 0);
    readout(0, 0, 0, 25, 0);
    drive(0, 0, 0, 0, 1, '0, '0, {{15{32'h0}}, 32'h7fff_ffff}, 40'h7f_ffff_ffff, "R5 preload");
    readout(1, 0, 0, 0, 1);
    readout(1, 0, 0, 32, 0);
    readout(0, 0, 0, 23, 0);
    readout(0, 0, 1, 63, 1);
    readout(0, 1, 0, 0, 1);
    repeat (2) @(posedge clk);
    #2;
    finish_run();
  end
endmodule